// File: doc/BRIEF.md
# I2C Target Address Match and Write Receiver

This block is the receive half of an I2C target node. It oversamples the SCL and SDA lines with the system clock and detects Start and Stop conditions. After each Start it collects the address byte and compares it against a configured own address in either 7-bit or 10-bit form. When the address matches, it acknowledges by pulling SDA low and then accepts the data bytes a controller writes to it. Every accepted byte, address or data, lands in a holding register with a one-cycle interrupt pulse and flags that tell the two kinds apart.

A mismatch at any stage of address recognition puts the receiver into a locked-out state that lasts until the next Stop, and a repeated Start does not end that state. An accept-all setting makes the node acknowledge every address, which lets it act as a repeater on a shared bus. Software empties the holding register through a pop strobe. A data byte that arrives while the register is still full is refused with a NACK.

Top module: `i2c_target_rx`

## Requirements
- R1: After reset the SDA pull output is inactive, the holding register is empty (rx_full_o = 0), irq_o = 0 and both type flags are 0.
- R2: In 7-bit mode, with accept-all off, the receiver acknowledges an address byte whose bits 7:1 equal own address bits 6:0. It pulls SDA low from the fall of the 8th SCL clock to the fall of the 9th. It pulses irq_o, loads the address byte into rx_data_o, sets rx_full_o, clears is_data_o and copies byte bit 0 into is_read_o.
- R3: After an address mismatch the receiver acknowledges nothing and ignores every byte and every repeated Start until a Stop. After that Stop, a new Start arms address detection again.
- R4: With accept-all off, the general call byte 0x00 is acknowledged in either address mode only while gcall_en_i = 1. Otherwise it counts as a mismatch.
- R5: In 10-bit mode the first address byte is acknowledged, with no interrupt, only when it has the form 11110 a9 a8 0, where a9 a8 equal own address bits 9:8. Any other first byte is a mismatch.
- R6: In 10-bit mode, after an acknowledged first byte, a second byte equal to own address bits 7:0 is acknowledged with an irq pulse, is loaded into rx_data_o with is_data_o = 0 and is_read_o = 0, and sets rx_full_o. Any other value is a mismatch.
- R7: With accept-all on, every address byte is handled as a full address match, whatever the own address, the 10-bit setting and the general call enable hold. is_read_o takes byte bit 0.
- R8: After a write address match, each data byte is complete at the fall of its 8th SCL clock. If the holding register is empty, the byte is acknowledged and loaded into rx_data_o, with rx_full_o = 1, is_data_o = 1 and one irq pulse.
- R9: A data byte that completes while rx_full_o = 1 gets a NACK. rx_data_o keeps its value, no irq pulse is raised and rx_full_o stays set. Only rx_pop_i clears rx_full_o.
- R10: A matched address with bit 0 = 1 (read) is acknowledged with is_read_o = 1. The receiver then releases SDA and ignores the bus until a Stop.
- R11: The SDA pull output changes only while the synchronized SCL is low, and irq_o is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| own_addr_i | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| ten_bit_i | input | 1 | 1 = 10-bit address mode |
| gcall_en_i | input | 1 | 1 = acknowledge general call 0x00 |
| accept_all_i | input | 1 | 1 = acknowledge every address |
| rx_pop_i | input | 1 | Clears rx_full_o |
| rx_data_o | output | 8 | Holding register: last accepted byte |
| rx_full_o | output | 1 | Holding register holds an unread byte |
| is_data_o | output | 1 | 1 = last byte was data, 0 = address |
| is_read_o | output | 1 | R/W bit of the last matched address |
| irq_o | output | 1 | One-cycle pulse per accepted byte |

## Verification
Each input edge passes two synchronizer flops and a previous-value flop before it is seen. The flag, holding register and SDA pull outputs therefore change on the third clock edge after the SCL input falls at the end of the 8th bit, and SDA is released three edges after the 9th fall. The bench reads the acknowledge from the open-drain bus at the middle of the 9th SCL high phase, well after the pull has settled. It reads flags, data and the running irq count four clock cycles after the 9th SCL fall, before the next bit begins. A refused or ignored byte is checked the same way: no acknowledge, holding register unchanged and irq count unchanged.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_DATA,
        ST_ACK,
        ST_IGNORE
    } rx_state_e;

    typedef enum logic [1:0] {
        DEC_REJECT,
        DEC_FULL,
        DEC_TEN_HI
    } addr_dec_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic [ADDR_W-1:0] own;
        logic              ten_bit;
        logic              gc_en;
        logic              accept_all;
    } cfg_t;

    function automatic logic ten_hi_ok(input logic [BYTE_W-1:0] b,
                                       input logic [1:0] own_hi);
        return (b[7:3] == TEN_BIT_TAG) && (b[2:1] == own_hi) && !b[0];
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        ev_o.scl      = scl_now;
        ev_o.sda      = sda_now;
        ev_o.scl_rise = scl_now & ~scl_q;
        ev_o.scl_fall = ~scl_now & scl_q;
        ev_o.start    = scl_now & scl_q & ~sda_now & sda_q;
        ev_o.stop     = scl_now & scl_q & sda_now & ~sda_q;
    end

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              full_o
);
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] sreg;

    assign full_o = (bit_cnt == CNT_W'(BYTE_W));
    assign byte_o = sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            sreg    <= '0;
        end else if (clr_i) begin
            bit_cnt <= '0;
        end else if (shift_i && !full_o) begin
            sreg    <= {sreg[BYTE_W-2:0], bit_i};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_rx_pkg::*;
(
    input  cfg_t              cfg_i,
    input  logic              second_i,
    input  logic [BYTE_W-1:0] byte_i,
    output addr_dec_e         dec_o
);
    always_comb begin
        dec_o = DEC_REJECT;
        if (second_i) begin
            if (byte_i == cfg_i.own[7:0]) dec_o = DEC_FULL;
        end else if (cfg_i.accept_all) begin
            dec_o = DEC_FULL;
        end else if (byte_i == '0) begin
            if (cfg_i.gc_en) dec_o = DEC_FULL;
        end else if (cfg_i.ten_bit) begin
            if (ten_hi_ok(byte_i, cfg_i.own[9:8])) dec_o = DEC_TEN_HI;
        end else if (byte_i[7:1] == cfg_i.own[6:0]) begin
            dec_o = DEC_FULL;
        end
    end

endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ten_bit_i,
    input  logic              gcall_en_i,
    input  logic              accept_all_i,
    input  logic              rx_pop_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              is_data_o,
    output logic              is_read_o,
    output logic              irq_o
);
    bus_ev_t           ev;
    cfg_t              cfg;
    rx_state_e         state;
    rx_state_e         ret_state;
    addr_dec_e         dec;
    logic [BYTE_W-1:0] shift_byte;
    logic              byte_full;
    logic              receiving;
    logic              second_phase;
    logic              shift_en;
    logic              shift_clr;
    logic              byte_done;
    logic              scl_sync;
    logic              in_ignore;

    assign cfg = '{own: own_addr_i, ten_bit: ten_bit_i,
                   gc_en: gcall_en_i, accept_all: accept_all_i};

    assign receiving    = (state == ST_ADDR1) || (state == ST_ADDR2) || (state == ST_DATA);
    assign second_phase = (state == ST_ADDR2);
    assign shift_en     = ev.scl_rise && receiving;
    assign shift_clr    = ev.start || ev.stop || ((state == ST_ACK) && ev.scl_fall);
    assign byte_done    = ev.scl_fall && byte_full && receiving;
    assign scl_sync     = ev.scl;
    assign in_ignore    = (state == ST_IGNORE);

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_byte_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (shift_clr),
        .shift_i (shift_en),
        .bit_i   (ev.sda),
        .byte_o  (shift_byte),
        .full_o  (byte_full)
    );

    i2c_addr_match u_match (
        .cfg_i    (cfg),
        .second_i (second_phase),
        .byte_i   (shift_byte),
        .dec_o    (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ret_state  <= ST_IDLE;
            sda_pull_o <= 1'b0;
            rx_data_o  <= '0;
            rx_full_o  <= 1'b0;
            is_data_o  <= 1'b0;
            is_read_o  <= 1'b0;
            irq_o      <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (rx_pop_i) rx_full_o <= 1'b0;
            if (ev.stop) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else if (ev.start && (state != ST_IGNORE)) begin
                state      <= ST_ADDR1;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR1, ST_ADDR2: begin
                        if (byte_done) begin
                            case (dec)
                                DEC_FULL: begin
                                    sda_pull_o <= 1'b1;
                                    rx_data_o  <= shift_byte;
                                    rx_full_o  <= 1'b1;
                                    is_data_o  <= 1'b0;
                                    is_read_o  <= second_phase ? 1'b0 : shift_byte[0];
                                    irq_o      <= 1'b1;
                                    ret_state  <= (!second_phase && shift_byte[0]) ? ST_IGNORE : ST_DATA;
                                    state      <= ST_ACK;
                                end
                                DEC_TEN_HI: begin
                                    sda_pull_o <= 1'b1;
                                    ret_state  <= ST_ADDR2;
                                    state      <= ST_ACK;
                                end
                                default: state <= ST_IGNORE;
                            endcase
                        end
                    end
                    ST_DATA: begin
                        if (byte_done) begin
                            state     <= ST_ACK;
                            ret_state <= ST_DATA;
                            if (!rx_full_o) begin
                                sda_pull_o <= 1'b1;
                                rx_data_o  <= shift_byte;
                                rx_full_o  <= 1'b1;
                                is_data_o  <= 1'b1;
                                irq_o      <= 1'b1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            state      <= ret_state;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_target_rx_chk.sv
module i2c_target_rx_chk
    import i2c_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_sync,
    input logic              in_ignore,
    input logic              sda_pull,
    input logic              irq,
    input logic              rx_full,
    input logic              rx_pop,
    input logic [BYTE_W-1:0] rx_data
);
    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_sync);

    p_irq_single_r11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_full_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> rx_full);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !irq |-> $stable(rx_data));

    p_full_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rx_pop) |=> rx_full);

    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        in_ignore |-> !sda_pull);

endmodule

bind i2c_target_rx i2c_target_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_sync  (scl_sync),
    .in_ignore (in_ignore),
    .sda_pull  (sda_pull_o),
    .irq       (irq_o),
    .rx_full   (rx_full_o),
    .rx_pop    (rx_pop_i),
    .rx_data   (rx_data_o)
);

// File: tb/test_i2c_target_rx.sv
`timescale 1ns/1ps
module test_i2c_target_rx;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_pull;
    logic [9:0] own_addr = 10'h25A;
    logic       ten_bit = 1'b0;
    logic       gc_en = 1'b0;
    logic       acc_all = 1'b0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       is_data;
    logic       is_read;
    logic       irq;
    int         irq_cnt = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;

    i2c_target_rx i_i2c_target_rx (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (m_scl),
        .sda_i        (sda_bus),
        .sda_pull_o   (sda_pull),
        .own_addr_i   (own_addr),
        .ten_bit_i    (ten_bit),
        .gcall_en_i   (gc_en),
        .accept_all_i (acc_all),
        .rx_pop_i     (rx_pop),
        .rx_data_o    (rx_data),
        .rx_full_o    (rx_full),
        .is_data_o    (is_data),
        .is_read_o    (is_read),
        .irq_o        (irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        wclk(H); m_sda = 1'b0; wclk(H); m_scl = 1'b0;
    endtask

    task automatic bus_rstart();
        wclk(H/2); m_sda = 1'b1; wclk(H/2); m_scl = 1'b1;
        wclk(H); m_sda = 1'b0; wclk(H); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(H/2); m_sda = 1'b0; wclk(H/2); m_scl = 1'b1;
        wclk(H); m_sda = 1'b1; wclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wclk(H/2); m_sda = b[i]; wclk(H/2);
            m_scl = 1'b1; wclk(H); m_scl = 1'b0;
        end
        wclk(H/2); m_sda = 1'b1; wclk(H/2);
        m_scl = 1'b1; wclk(H/2);
        ack = ~sda_bus;
        wclk(H/2); m_scl = 1'b0;
        wclk(4);
    endtask

    task automatic pop();
        rx_pop = 1'b1; wclk(1); rx_pop = 1'b0; wclk(1);
    endtask

    initial begin
        logic ack;
        int   i0;
        logic [7:0] d0;
        wclk(4);
        rst = 1'b0;
        wclk(2);
        chk("R1 pull", sda_pull, 0);
        chk("R1 full", rx_full, 0);
        chk("R1 irq", irq, 0);
        chk("R1 flags", {is_data, is_read}, 0);

        // R2 / R3 / R4: sweep all 7-bit write addresses, general call off
        for (int a = 0; a < 128; a++) begin
            logic exp;
            exp = (a == 'h5A);
            i0 = irq_cnt;
            bus_start();
            send_byte(8'(a << 1), ack);
            chk(a == 0 ? "R4 gc off" : (exp ? "R2 ack" : "R3 nack"), ack, exp);
            chk("R2 irq", irq_cnt - i0, exp ? 1 : 0);
            if (exp) begin
                chk("R2 data", rx_data, 8'hB4);
                chk("R2 flags", {is_data, is_read, rx_full}, 3'b001);
            end else begin
                send_byte(8'hB4, ack);
                chk("R3 ignored", ack, 0);
            end
            bus_stop();
            pop();
        end

        // R3: repeated Start does not end the lockout
        bus_start();
        send_byte(8'h10, ack);
        bus_rstart();
        send_byte(8'hB4, ack);
        chk("R3 rstart locked", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hB4, ack);
        chk("R3 rearm after stop", ack, 1);
        bus_stop();
        pop();

        // R4: general call enabled, both modes
        gc_en = 1'b1;
        for (int m = 0; m < 2; m++) begin
            ten_bit = m[0];
            i0 = irq_cnt;
            bus_start();
            send_byte(8'h00, ack);
            chk("R4 gc ack", ack, 1);
            chk("R4 gc irq", irq_cnt - i0, 1);
            chk("R4 gc flags", {is_data, is_read}, 0);
            bus_stop();
            pop();
        end
        gc_en = 1'b0;
        ten_bit = 1'b0;

        // R8 / R9: data path and overflow
        bus_start();
        send_byte(8'hB4, ack);
        pop();
        i0 = irq_cnt;
        send_byte(8'h3C, ack);
        chk("R8 ack", ack, 1);
        chk("R8 data", rx_data, 8'h3C);
        chk("R8 flags", {is_data, rx_full}, 2'b11);
        chk("R8 irq", irq_cnt - i0, 1);
        i0 = irq_cnt;
        send_byte(8'hC3, ack);
        chk("R9 nack", ack, 0);
        chk("R9 held", rx_data, 8'h3C);
        chk("R9 no irq", irq_cnt - i0, 0);
        chk("R9 still full", rx_full, 1);
        pop();
        chk("R9 pop clears", rx_full, 0);
        send_byte(8'h77, ack);
        chk("R8 ack after pop", ack, 1);
        chk("R8 data after pop", rx_data, 8'h77);
        bus_stop();
        pop();

        // R10: read address
        i0 = irq_cnt;
        bus_start();
        send_byte(8'hB5, ack);
        chk("R10 ack", ack, 1);
        chk("R10 read flag", is_read, 1);
        chk("R10 irq", irq_cnt - i0, 1);
        send_byte(8'hFF, ack);
        chk("R10 ignored", ack, 0);
        bus_stop();
        pop();

        // R5: 10-bit first byte sweep
        ten_bit = 1'b1;
        for (int f = 0; f < 8; f++) begin
            logic [7:0] b;
            logic exp;
            b = 8'hF0 | 8'(f[1:0] << 1) | 8'(f[2]);
            exp = (f[1:0] == 2'd2) && !f[2];
            i0 = irq_cnt;
            bus_start();
            send_byte(b, ack);
            chk("R5 first byte", ack, exp);
            chk("R5 no irq", irq_cnt - i0, 0);
            send_byte(8'h5A, ack);
            chk(exp ? "R6 second ack" : "R5 ignored", ack, exp);
            bus_stop();
            pop();
        end
        bus_start();
        send_byte(8'hB4, ack);
        chk("R5 7-bit form rejected", ack, 0);
        bus_stop();

        // R6: 10-bit second byte sweep
        for (int s = 0; s < 32; s++) begin
            logic [7:0] b;
            logic exp;
            b = 8'(s * 8 + 2);
            exp = (b == 8'h5A);
            bus_start();
            send_byte(8'hF4, ack);
            i0 = irq_cnt;
            send_byte(b, ack);
            chk("R6 second", ack, exp);
            chk("R6 irq", irq_cnt - i0, exp ? 1 : 0);
            if (exp) begin
                chk("R6 data", rx_data, 8'h5A);
                chk("R6 flags", {is_data, is_read, rx_full}, 3'b001);
                pop();
                send_byte(8'h21, ack);
                chk("R8 10-bit data", rx_data, 8'h21);
            end else begin
                send_byte(8'h21, ack);
                chk("R6 ignored", ack, 0);
            end
            bus_stop();
            pop();
        end

        // R7: accept-all overrides address, mode and general call
        acc_all = 1'b1;
        own_addr = 10'h301;
        for (int i = 0; i < 64; i++) begin
            logic [7:0] b;
            b = 8'(i * 4 + (i & 1));
            d0 = b;
            i0 = irq_cnt;
            bus_start();
            send_byte(b, ack);
            chk("R7 ack", ack, 1);
            chk("R7 irq", irq_cnt - i0, 1);
            chk("R7 data", rx_data, d0);
            chk("R7 rw", is_read, d0[0]);
            chk("R7 type", is_data, 0);
            bus_stop();
            pop();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule